// File: doc/BRIEF.md
# PHY Register Access Master (Four-Phase Handshake)

This block lets on-chip logic read and write 16-bit registers inside a PHY that has no memory-mapped access. The PHY side sees one 20-bit control word and returns an acknowledge level and 16 bits of read data. Every step of a transfer is a full four-phase handshake: raise one strobe, wait for the acknowledge to rise, lower the strobe, and wait for the acknowledge to fall.

A client presents a request with a direction, an address and write data. It is accepted while `req_ready` is high. Every transfer starts with an address phase. A read then runs a read-strobe handshake and captures the PHY data. A write runs a data-capture handshake and then a write-strobe handshake. Each wait for the acknowledge samples a synchronised copy of it a bounded number of times at a fixed spacing. If the expected level never appears, the transfer is abandoned: all strobes drop and a timeout pulse is returned.

Top module: `phy_ctl_master`

## Requirements
- R1: The control word `phy_ctrl` carries the address/data bus in bits 15:0, capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. At most one of bits 19:16 is set at any time.
- R2: The address phase places the address on bits 15:0 one cycle before capture-address rises, then holds the strobe until a high acknowledge is seen. It drops the strobe while keeping the address on the bus and waits for a low acknowledge. The word sequence is A, A|cap-addr, A.
- R3: A read, after the address phase, drives the read strobe with bits 15:0 at zero and waits for a high acknowledge. It captures `phy_rdata`, clears the whole control word and waits for a low acknowledge. It then pulses `rsp_done` with the captured value on `rsp_rdata`.
- R4: A write, after the address phase, drives the data alone for one cycle and then adds capture-data. It waits for a high acknowledge, drops capture-data while keeping the data, and waits for a low acknowledge. It then drives the write strobe with bits 15:0 at zero, and on a high acknowledge it returns to the data alone. On a low acknowledge it returns the control word to zero and pulses `rsp_done`.
- R5: Each acknowledge wait samples the synchronised acknowledge at most ACK_TRIES times, SAMPLE_GAP cycles apart. If none of these samples matches, the block clears the control word to zero, pulses `rsp_timeout` and returns to idle. With a silent PHY the timeout comes (ACK_TRIES-1)*SAMPLE_GAP+3 cycles after the request is accepted.
- R6: A timeout is detected in any wait: an acknowledge stuck high during a low-level wait, and a missing acknowledge in the middle of a write.
- R7: `req_ready` is high only in idle. A request presented while a transfer is running is ignored and produces no control-word activity.
- R8: `rsp_done` and `rsp_timeout` are single-cycle pulses and are never high together. `rsp_rdata` keeps the value of the last completed read across writes and timeouts.
- R9: After reset the control word is zero, `req_ready` is high, and both response pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle; a request would be accepted |
| rsp_rdata | output | 16 | Data of the last completed read |
| rsp_done | output | 1 | One-cycle pulse: transfer completed |
| rsp_timeout | output | 1 | One-cycle pulse: transfer abandoned on an acknowledge timeout |
| phy_ctrl | output | 20 | Control word to the PHY (bus and four strobes) |
| phy_ack | input | 1 | Acknowledge from the PHY (asynchronous) |
| phy_rdata | input | 16 | Read data from the PHY, valid while the acknowledge is high |

## Verification
A scoreboard compares every change of the control word against the expected four-phase sequence. This catches a strobe raised together with its bus value, a bus that is not held when a strobe drops, or stray bus bits during the read or write strobe, each of which appears as a wrong word. The responder has four modes: normal, silent, acknowledge stuck high, and no acknowledge to the write strobe. A design that timed out only on one acknowledge level, or left a strobe set after aborting, would hang or show extra words. The timeout delay is measured, so a miscounted number of samples moves the pulse out of its window. A request held during a busy read would show up as unexpected words. A clobbered `rsp_rdata` after a write shows up as a data mismatch.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADR_SET,
      ST_ADR_HI,
      ST_ADR_LO,
      ST_RD_HI,
      ST_RD_LO,
      ST_DAT_SET,
      ST_DAT_HI,
      ST_DAT_LO,
      ST_WR_HI,
      ST_WR_LO
   } seq_state_t;

   // State holds a strobe or its release and waits for the acknowledge
   function automatic logic st_waits(seq_state_t s);
      return s inside {ST_ADR_HI, ST_ADR_LO, ST_RD_HI, ST_RD_LO,
                       ST_DAT_HI, ST_DAT_LO, ST_WR_HI, ST_WR_LO};
   endfunction

   // Level of acknowledge the waiting state is looking for
   function automatic logic st_wants_high(seq_state_t s);
      return s inside {ST_ADR_HI, ST_RD_HI, ST_DAT_HI, ST_WR_HI};
   endfunction

endpackage

// File: rtl/phyacc_sync.sv
module phyacc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("phyacc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/phyacc_ack_timer.sv
module phyacc_ack_timer #(
   parameter int TRIES = 10,
   parameter int GAP   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic want_high,
   input  logic ack_s,
   output logic hit,
   output logic expire
);
   localparam int TW = $clog2(TRIES + 1);
   localparam int GW = $clog2(GAP + 1);

   generate
      if (TRIES < 1) begin : g_bad_tries
         $error("phyacc_ack_timer: TRIES must be at least 1");
      end
      if (GAP < 1) begin : g_bad_gap
         $error("phyacc_ack_timer: GAP must be at least 1");
      end
   endgenerate

   logic [TW-1:0] tries_q;
   logic [GW-1:0] gap_q;
   logic          sample;

   assign sample = active && (gap_q == '0);
   assign hit    = sample && (ack_s == want_high);
   assign expire = sample && !hit && (tries_q == TW'(TRIES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tries_q <= '0;
         gap_q   <= '0;
      end else if (!active || hit || expire) begin
         tries_q <= '0;
         gap_q   <= '0;
      end else if (sample) begin
         tries_q <= tries_q + TW'(1);
         gap_q   <= GW'(GAP - 1);
      end else begin
         gap_q   <= gap_q - GW'(1);
      end
   end
endmodule

// File: rtl/phyacc_seq.sv
module phyacc_seq
   import phyacc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              hit,
   input  logic              expire,
   input  logic [DATA_W-1:0] rd_bus,
   output seq_state_t        state,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              wait_active,
   output logic              want_high,
   output logic              req_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              rsp_timeout
);
   logic wr_q;

   assign wait_active = st_waits(state);
   assign want_high   = st_wants_high(state);
   assign req_ready   = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         addr_q      <= '0;
         wdata_q     <= '0;
         wr_q        <= 1'b0;
         rsp_rdata   <= '0;
         rsp_done    <= 1'b0;
         rsp_timeout <= 1'b0;
      end else begin
         rsp_done    <= 1'b0;
         rsp_timeout <= 1'b0;
         if (expire) begin
            state       <= ST_IDLE;
            rsp_timeout <= 1'b1;
         end else begin
            case (state)
               ST_IDLE: if (req_valid) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  wr_q    <= req_write;
                  state   <= ST_ADR_SET;
               end
               ST_ADR_SET: state <= ST_ADR_HI;
               ST_ADR_HI:  if (hit) state <= ST_ADR_LO;
               ST_ADR_LO:  if (hit) state <= wr_q ? ST_DAT_SET : ST_RD_HI;
               ST_RD_HI: if (hit) begin
                  rsp_rdata <= rd_bus;
                  state     <= ST_RD_LO;
               end
               ST_RD_LO: if (hit) begin
                  state    <= ST_IDLE;
                  rsp_done <= 1'b1;
               end
               ST_DAT_SET: state <= ST_DAT_HI;
               ST_DAT_HI:  if (hit) state <= ST_DAT_LO;
               ST_DAT_LO:  if (hit) state <= ST_WR_HI;
               ST_WR_HI:   if (hit) state <= ST_WR_LO;
               ST_WR_LO: if (hit) begin
                  state    <= ST_IDLE;
                  rsp_done <= 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/phyacc_cw_enc.sv
module phyacc_cw_enc
   import phyacc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  seq_state_t        state,
   input  logic [DATA_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W+3:0] cw
);
   localparam int POS_CAP_ADDR = DATA_W;
   localparam int POS_CAP_DATA = DATA_W + 1;
   localparam int POS_WRITE    = DATA_W + 2;
   localparam int POS_READ     = DATA_W + 3;

   always_comb begin
      cw = '0;
      case (state)
         ST_ADR_SET, ST_ADR_LO: cw[DATA_W-1:0] = addr_q;
         ST_ADR_HI: begin
            cw[DATA_W-1:0]   = addr_q;
            cw[POS_CAP_ADDR] = 1'b1;
         end
         ST_RD_HI:  cw[POS_READ] = 1'b1;
         ST_DAT_SET, ST_DAT_LO, ST_WR_LO: cw[DATA_W-1:0] = wdata_q;
         ST_DAT_HI: begin
            cw[DATA_W-1:0]   = wdata_q;
            cw[POS_CAP_DATA] = 1'b1;
         end
         ST_WR_HI:  cw[POS_WRITE] = 1'b1;
         default:   cw = '0;
      endcase
   end
endmodule

// File: rtl/phy_ctl_master.sv
module phy_ctl_master
   import phyacc_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ACK_TRIES   = 10,
   parameter int SAMPLE_GAP  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              rsp_timeout,
   output logic [DATA_W+3:0] phy_ctrl,
   input  logic              phy_ack,
   input  logic [DATA_W-1:0] phy_rdata
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("phy_ctl_master: DATA_W must be positive");
      end
   endgenerate

   seq_state_t        state;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              ack_s;
   logic              wait_active;
   logic              want_high;
   logic              hit;
   logic              expire;

   phyacc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (phy_ack),
      .q     (ack_s)
   );

   phyacc_ack_timer #(.TRIES(ACK_TRIES), .GAP(SAMPLE_GAP)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (wait_active),
      .want_high (want_high),
      .ack_s     (ack_s),
      .hit       (hit),
      .expire    (expire)
   );

   phyacc_seq #(.DATA_W(DATA_W)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .hit         (hit),
      .expire      (expire),
      .rd_bus      (phy_rdata),
      .state       (state),
      .addr_q      (addr_q),
      .wdata_q     (wdata_q),
      .wait_active (wait_active),
      .want_high   (want_high),
      .req_ready   (req_ready),
      .rsp_rdata   (rsp_rdata),
      .rsp_done    (rsp_done),
      .rsp_timeout (rsp_timeout)
   );

   phyacc_cw_enc #(.DATA_W(DATA_W)) i_enc (
      .state   (state),
      .addr_q  (addr_q),
      .wdata_q (wdata_q),
      .cw      (phy_ctrl)
   );
endmodule

// File: rtl/phyacc_chk.sv
module phyacc_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W+3:0] phy_ctrl,
   input logic              req_ready,
   input logic              rsp_done,
   input logic              rsp_timeout
);
   localparam int P_CA = DATA_W;
   localparam int P_CD = DATA_W + 1;
   localparam int P_WR = DATA_W + 2;
   localparam int P_RD = DATA_W + 3;

   p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phy_ctrl[P_RD:P_CA]));

   p_addr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_ctrl[P_CA]) |-> $stable(phy_ctrl[DATA_W-1:0]));

   p_addr_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phy_ctrl[P_CA]) && !rsp_timeout) |-> $stable(phy_ctrl[DATA_W-1:0]));

   p_read_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phy_ctrl[P_RD] |-> (phy_ctrl[DATA_W-1:0] == '0));

   p_data_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_ctrl[P_CD]) |-> $stable(phy_ctrl[DATA_W-1:0]));

   p_write_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phy_ctrl[P_WR] |-> (phy_ctrl[DATA_W-1:0] == '0));

   p_timeout_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_timeout |-> (phy_ctrl == '0 && req_ready));

   p_busy_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|phy_ctrl[P_RD:P_CA]) |-> !req_ready);

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_done && rsp_timeout));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_tmo_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_timeout |=> !rsp_timeout);
endmodule

bind phy_ctl_master phyacc_chk #(.DATA_W(DATA_W)) i_phyacc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .phy_ctrl    (phy_ctrl),
   .req_ready   (req_ready),
   .rsp_done    (rsp_done),
   .rsp_timeout (rsp_timeout)
);

// File: tb/test_phy_ctl_master.sv
module test_phy_ctl_master;
   localparam int DW    = 16;
   localparam int CWW   = DW + 4;
   localparam int TRIES = 10;
   localparam int GAP   = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic [DW-1:0]  req_addr = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic           req_ready;
   logic [DW-1:0]  rsp_rdata;
   logic           rsp_done;
   logic           rsp_timeout;
   logic [CWW-1:0] phy_ctrl;
   logic           phy_ack = 1'b0;
   logic [DW-1:0]  phy_rdata = '0;

   always #5 clk = ~clk;

   phy_ctl_master #(.DATA_W(DW), .ACK_TRIES(TRIES), .SAMPLE_GAP(GAP), .SYNC_STAGES(2))
   i_phy_ctl_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
      .phy_ctrl(phy_ctrl), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // ---------------- responder model ----------------
   // mode 0 normal, 1 silent, 2 ack stuck high, 3 no ack to write strobe
   int            mode = 0;
   logic [DW-1:0] lat_addr = '0;
   logic [DW-1:0] lat_data = '0;
   logic [DW-1:0] regs [256];

   initial for (int i = 0; i < 256; i++) regs[i] = 16'h0;

   always @(negedge clk) begin
      if (!rst_n) begin
         phy_ack   = 1'b0;
         phy_rdata = '0;
      end else begin
         case (mode)
            1:       phy_ack = 1'b0;
            2:       phy_ack = 1'b1;
            3:       phy_ack = phy_ctrl[19] | phy_ctrl[17] | phy_ctrl[16];
            default: phy_ack = |phy_ctrl[19:16];
         endcase
         if (phy_ctrl[16]) lat_addr = phy_ctrl[15:0];
         if (phy_ctrl[17]) lat_data = phy_ctrl[15:0];
         if (phy_ctrl[18] && mode == 0) regs[lat_addr[7:0]] = lat_data;
         if (phy_ctrl[19]) phy_rdata = regs[lat_addr[7:0]];
      end
   end

   // ---------------- scoreboard ----------------
   logic [CWW-1:0] exp_cw_q[$];
   string          exp_tag_q[$];
   logic [CWW-1:0] last_pushed = '0;

   typedef struct {
      bit            tmo;
      bit            chk_data;
      logic [DW-1:0] data;
      string         tag;
   } rsp_t;
   rsp_t exp_rsp_q[$];

   logic [DW-1:0] last_read = '0;

   task automatic push_cw(input logic [CWW-1:0] w, input string tag);
      if (w != last_pushed) begin
         exp_cw_q.push_back(w);
         exp_tag_q.push_back(tag);
         last_pushed = w;
      end
   endtask

   task automatic push_rsp(input bit tmo, input bit chk, input logic [DW-1:0] d, input string tag);
      rsp_t r;
      r.tmo = tmo; r.chk_data = chk; r.data = d; r.tag = tag;
      exp_rsp_q.push_back(r);
   endtask

   task automatic exp_addr_phase(input logic [DW-1:0] a);
      push_cw({4'b0000, a}, "R2");
      push_cw({4'b0001, a}, "R2");
      push_cw({4'b0000, a}, "R2");
   endtask

   task automatic exp_read(input logic [DW-1:0] a, input logic [DW-1:0] d);
      exp_addr_phase(a);
      push_cw({4'b1000, 16'h0}, "R3");
      push_cw('0, "R3");
      push_rsp(1'b0, 1'b1, d, "R3");
      last_read = d;
   endtask

   task automatic exp_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
      exp_addr_phase(a);
      push_cw({4'b0000, d}, "R4");
      push_cw({4'b0010, d}, "R4");
      push_cw({4'b0000, d}, "R4");
      push_cw({4'b0100, 16'h0}, "R4");
      push_cw({4'b0000, d}, "R4");
      push_cw('0, "R4");
      push_rsp(1'b0, 1'b1, last_read, "R8");
   endtask

   logic [CWW-1:0] prev_cw = '0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (phy_ctrl !== prev_cw) begin
            if (exp_cw_q.size() == 0) begin
               check(1'b0, "R7", "unexpected control word", 32'(phy_ctrl), 32'(prev_cw));
            end else begin
               logic [CWW-1:0] e;
               string t;
               e = exp_cw_q.pop_front();
               t = exp_tag_q.pop_front();
               check(phy_ctrl === e, t, "control word", 32'(phy_ctrl), 32'(e));
            end
            prev_cw = phy_ctrl;
         end
         if (rsp_done || rsp_timeout) begin
            if (exp_rsp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected response", {30'd0, rsp_timeout, rsp_done}, 32'd0);
            end else begin
               rsp_t r;
               r = exp_rsp_q.pop_front();
               check(rsp_timeout === r.tmo && rsp_done === !r.tmo, r.tag, "response kind",
                     {30'd0, rsp_timeout, rsp_done}, {30'd0, r.tmo, !r.tmo});
               if (r.chk_data)
                  check(rsp_rdata === r.data, r.tag, "response data", 32'(rsp_rdata), 32'(r.data));
            end
         end
      end
   end

   // ---------------- driver ----------------
   int t_start = 0;

   task automatic start_op(input bit w, input logic [DW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      t_start = cyc;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp();
      while (!(rsp_done || rsp_timeout)) @(negedge clk);
      repeat (4) @(negedge clk);
      check(exp_cw_q.size() == 0 && exp_rsp_q.size() == 0, "R7", "scoreboard drained",
            32'(exp_cw_q.size() + exp_rsp_q.size()), 32'd0);
   endtask

   task automatic do_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
      exp_write(a, d);
      start_op(1'b1, a, d);
      wait_rsp();
   endtask

   task automatic do_read(input logic [DW-1:0] a, input logic [DW-1:0] d);
      exp_read(a, d);
      start_op(1'b0, a, 16'h0);
      wait_rsp();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(phy_ctrl === '0, "R9", "ctrl in reset", 32'(phy_ctrl), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1, "R9", "ready after reset", 32'(req_ready), 32'd1);
      check(rsp_done === 1'b0 && rsp_timeout === 1'b0, "R9", "no response after reset",
            {30'd0, rsp_timeout, rsp_done}, 32'd0);

      // R4 / R2: writes, including address equal to data
      do_write(16'h0012, 16'hBEEF);
      do_write(16'h0034, 16'h1234);
      do_write(16'h00A5, 16'h00A5);
      // R3: reads return stored values
      do_read(16'h0012, 16'hBEEF);
      do_read(16'h00A5, 16'h00A5);
      // R8: rdata unchanged by a write
      do_write(16'h0040, 16'h8001);
      do_read(16'h0034, 16'h1234);
      do_read(16'h0040, 16'h8001);

      // R7: request during a busy read is ignored
      exp_read(16'h0012, 16'hBEEF);
      start_op(1'b0, 16'h0012, 16'h0);
      repeat (3) @(negedge clk);
      check(req_ready === 1'b0, "R7", "ready while busy", 32'(req_ready), 32'd0);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0077; req_wdata = 16'h5555;
      repeat (6) @(negedge clk);
      req_valid = 1'b0;
      wait_rsp();
      do_read(16'h0077, 16'h0000);

      // R5: silent PHY, timeout in the first wait, with its delay
      mode = 1;
      push_cw({4'b0000, 16'h0021}, "R5");
      push_cw({4'b0001, 16'h0021}, "R5");
      push_cw('0, "R5");
      push_rsp(1'b1, 1'b0, 16'h0, "R5");
      start_op(1'b0, 16'h0021, 16'h0);
      while (!(rsp_done || rsp_timeout)) @(negedge clk);
      check((cyc - t_start) >= (TRIES-1)*GAP && (cyc - t_start) <= (TRIES-1)*GAP + 6,
            "R5", "timeout delay", 32'(cyc - t_start), 32'((TRIES-1)*GAP + 3));
      check(phy_ctrl === '0 && req_ready === 1'b1, "R5", "idle after timeout",
            {11'd0, req_ready, phy_ctrl}, {11'd0, 1'b1, 20'd0});
      wait_rsp();

      // R6: acknowledge stuck high, timeout in the low wait
      mode = 2;
      repeat (4) @(negedge clk);
      push_cw({4'b0000, 16'h0022}, "R6");
      push_cw({4'b0001, 16'h0022}, "R6");
      push_cw({4'b0000, 16'h0022}, "R6");
      push_cw('0, "R6");
      push_rsp(1'b1, 1'b0, 16'h0, "R6");
      start_op(1'b0, 16'h0022, 16'h0);
      wait_rsp();

      // R6: no acknowledge to write strobe, abort mid-write
      mode = 3;
      repeat (4) @(negedge clk);
      exp_addr_phase(16'h0023);
      push_cw({4'b0000, 16'hC3C3}, "R6");
      push_cw({4'b0010, 16'hC3C3}, "R6");
      push_cw({4'b0000, 16'hC3C3}, "R6");
      push_cw({4'b0100, 16'h0}, "R6");
      push_cw('0, "R6");
      push_rsp(1'b1, 1'b0, 16'h0, "R6");
      start_op(1'b1, 16'h0023, 16'hC3C3);
      wait_rsp();
      check(rsp_rdata === last_read, "R8", "rdata kept after timeout", 32'(rsp_rdata), 32'(last_read));

      // recovery: normal operation after timeouts
      mode = 0;
      repeat (4) @(negedge clk);
      do_write(16'h0023, 16'h0F0F);
      do_read(16'h0023, 16'h0F0F);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule